// File: doc/BRIEF.md
# Dual-Length Serial Configuration Shift Register

This block is the loading front end of a sixteen-channel LED driver. A host shifts a packet in bit by bit, most significant bit first, and then raises a level-sensitive strobe. The packet lands in one of two registers, depending on a mode input. In grayscale mode the shift path is 192 bits long and holds sixteen 12-bit brightness values. In correction mode it is 96 bits long and holds sixteen 6-bit current-trim values. The serial output taps the top of the active length, so several of these blocks can be chained.

After every grayscale load, the shift path is refilled with a 192-bit status word. The host can clock that word out while it shifts in the next packet. The status word carries the per-channel open-load flags, the over-temperature flag and a copy of the correction register. Both flags come from outside as inputs. Everything runs on one system clock. The serial clock and the strobe are sampled on that clock, and all action happens on their detected edges.

Top module: `cfg_shift_chain`

## Requirements
- R1: The shift path moves by exactly one bit on each rising edge of `sclk_i` (low in one sample, high in the next). The bit on `sdata_i` enters at bit 0, and a high level held for several cycles shifts only once.
- R2: `sdata_o` is bit 95 of the shift path when the effective mode is 1 (correction) and bit 191 when it is 0 (grayscale). A bit shifted in therefore appears at `sdata_o` after 96 or 192 shifts.
- R3: In grayscale mode, `gray_o` follows the whole shift path while `strobe_i` is high and holds while it is low. Channel n sits at `gray_o[12n+11:12n]`, so the first-shifted bit ends in channel 15 bit 11.
- R4: In correction mode, `corr_o` follows shift-path bits 95:0 while `strobe_i` is high and holds while it is low. Channel n sits at `corr_o[6n+5:6n]`. `corr_o` never changes while `strobe_i` is low.
- R5: A grayscale strobe falling edge replaces the shift path with the status word. The status word holds `open_flags_i` at bits 15:0, `therm_flag_i` at bit 16 and `corr_o` at bits 119:24. All other bits are zero.
- R6: The status word's bit 191 is on `sdata_o` right after the reload. Each later shift rising edge presents the next lower bit.
- R7: The first grayscale strobe after a correction load does not update `gray_o`. Instead, the next shift rising edge loads `gray_o` from the shift path and reloads the status word (with the flags of that edge) in place of a shift. Later grayscale strobes behave as in R3.
- R8: While `strobe_i` is high, a change on `mode_i` is ignored and `mode_err_o` goes to 1. `mode_err_o` stays 1 until reset. The new mode takes effect once the strobe is low.
- R9: After reset, `gray_o`, `corr_o`, `sdata_o` and `mode_err_o` are all 0.
- R10: The flags in the status word are those present at the reloading edge. Flag changes after that edge do not alter the word being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = correction load, 0 = grayscale load |
| sclk_i | input | 1 | Serial shift clock, sampled on `clk` |
| sdata_i | input | 1 | Serial data in, MSB first |
| strobe_i | input | 1 | Level-sensitive latch strobe |
| open_flags_i | input | 16 | Per-channel open-load flags |
| therm_flag_i | input | 1 | Over-temperature flag |
| sdata_o | output | 1 | Serial data out (chain / status readback) |
| gray_o | output | 192 | Grayscale register, 12 bits per channel |
| corr_o | output | 96 | Correction register, 6 bits per channel |
| mode_err_o | output | 1 | Sticky flag: mode changed during strobe |

## Verification
The assertions assume that `sclk_i`, `sdata_i`, `strobe_i` and `mode_i` are synchronous to `clk`. They also assume a shift pulse is at least one sample high and one low, so that edge detection on the sampled copies is exact. The stimulus applies every input change on the falling edge of `clk` and builds each shift pulse from one high sample followed by one low one. It holds the mode steady for two samples before shifting. It breaks this pattern only on purpose: once to hold the shift clock high for several samples, and once to flip the mode while the strobe is high.

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int NCH = 16,
  parameter int GW  = 12,
  parameter int CW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_i,
  input  logic                sclk_i,
  input  logic                sdata_i,
  input  logic                strobe_i,
  input  logic [NCH-1:0]      open_flags_i,
  input  logic                therm_flag_i,
  output logic                sdata_o,
  output logic [NCH*GW-1:0]   gray_o,
  output logic [NCH*CW-1:0]   corr_o,
  output logic                mode_err_o
);
  localparam int GBITS    = NCH * GW;
  localparam int CBITS    = NCH * CW;
  localparam int CORR_LSB = ((NCH + 1 + 7) / 8) * 8;

  logic [GBITS-1:0] shreg, gray_q, status;
  logic [CBITS-1:0] corr_q;
  logic sclk_q, strobe_q, mode_q, pend_q, arm_q, err_q;

  wire sc_rise   = sclk_i & ~sclk_q;
  wire st_fall   = strobe_q & ~strobe_i;
  wire gray_open = strobe_i & ~mode_q & ~pend_q;
  wire corr_open = strobe_i & mode_q;
  wire gray_fall = st_fall & ~mode_q & ~pend_q;
  wire finish    = arm_q & sc_rise;
  wire err_set   = strobe_i & (mode_i != mode_q);

  always_comb begin
    status = '0;
    status[NCH-1:0] = open_flags_i;
    status[NCH] = therm_flag_i;
    status[CORR_LSB +: CBITS] = corr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      gray_q   <= '0;
      corr_q   <= '0;
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      mode_q   <= 1'b0;
      pend_q   <= 1'b0;
      arm_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      sclk_q   <= sclk_i;
      strobe_q <= strobe_i;
      if (!strobe_i) mode_q <= mode_i;
      if (err_set) err_q <= 1'b1;
      if (gray_open) gray_q <= shreg;
      if (corr_open) corr_q <= shreg[CBITS-1:0];
      if (st_fall & mode_q) pend_q <= 1'b1;
      if (st_fall & ~mode_q & pend_q) arm_q <= 1'b1;
      if (finish) begin
        gray_q <= shreg;
        shreg  <= status;
        arm_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (gray_fall) begin
        shreg <= status;
      end else if (sc_rise) begin
        shreg <= {shreg[GBITS-2:0], sdata_i};
      end
    end
  end

  assign sdata_o    = mode_q ? shreg[CBITS-1] : shreg[GBITS-1];
  assign gray_o     = gray_q;
  assign corr_o     = corr_q;
  assign mode_err_o = err_q;

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> $stable(mode_q));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> mode_err_o);

  assert_status_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gray_fall |=> (shreg[NCH:0] == {$past(therm_flag_i), $past(open_flags_i)}) &&
                  (shreg[GBITS-1:CORR_LSB+CBITS] == '0) &&
                  (shreg[CORR_LSB-1:NCH+1] == '0));

  assert_corr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(corr_o));

  assert_gray_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !arm_q) |=> $stable(gray_o));

  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_rise && !finish && !gray_fall) |=>
      (shreg[0] == $past(sdata_i)) && (shreg[GBITS-1:1] == $past(shreg[GBITS-2:0])));
endmodule

// File: tb/cfg_shift_chain_tb_top.sv
module cfg_shift_chain_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0, strobe_i = 1'b0;
  logic [15:0] open_flags_i = '0;
  logic therm_flag_i = 1'b0;
  logic sdata_o, mode_err_o;
  logic [191:0] gray_o;
  logic [95:0] corr_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_shift_chain dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .strobe_i(strobe_i), .open_flags_i(open_flags_i), .therm_flag_i(therm_flag_i),
    .sdata_o(sdata_o), .gray_o(gray_o), .corr_o(corr_o), .mode_err_o(mode_err_o));

  function automatic logic [191:0] rnd192();
    logic [191:0] v;
    for (int w = 0; w < 6; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [191:0] stat_word(input logic [15:0] of, input logic tf,
                                             input logic [95:0] cr);
    logic [191:0] s = '0;
    s[15:0] = of;
    s[16] = tf;
    s[119:24] = cr;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [191:0] act,
                       input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    sdata_i = b; sclk_i = 1'b1;
    @(negedge clk) sclk_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_pkt(input logic [191:0] d, input int n, output logic [191:0] seen);
    seen = '0;
    for (int k = 0; k < n; k++) begin
      seen[n-1-k] = sdata_o;
      pulse(d[n-1-k]);
    end
  endtask

  task automatic set_mode(input logic m);
    mode_i = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_hi();
    strobe_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_lo();
    strobe_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [191:0] p1, p2, p3, p4, pk, seen, s_exp, c0, c1;
    logic [15:0] fl;
    logic tf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(gray_o == '0 && corr_o == '0, "R9 reset registers", {gray_o[95:0], corr_o}, '0);
    check(sdata_o == 1'b0 && mode_err_o == 1'b0, "R9 reset outputs",
          {sdata_o, mode_err_o}, '0);

    // grayscale load, normal path
    p1 = rnd192();
    shift_pkt(p1, 192, seen);
    check(gray_o == '0, "R3 hold before strobe", gray_o, '0);
    check(sdata_o == p1[191], "R2 gray tap bit 191", sdata_o, p1[191]);
    fl = 16'hA5C3; tf = 1'b1;
    open_flags_i = fl; therm_flag_i = tf;
    strobe_hi();
    check(gray_o == p1, "R3 transparent load", gray_o, p1);
    check(gray_o[11:0] == p1[11:0] && gray_o[191:180] == p1[191:180],
          "R3 channel 0 and 15 fields", gray_o, p1);
    strobe_lo();
    s_exp = stat_word(fl, tf, '0);
    check(sdata_o == s_exp[191], "R6 status msb on output", sdata_o, s_exp[191]);
    open_flags_i = 16'h0000; therm_flag_i = 1'b0;
    p2 = rnd192();
    shift_pkt(p2, 192, seen);
    check(seen == s_exp, "R5 R10 status readout with flags at falling edge", seen, s_exp);
    check(gray_o == p1, "R3 hold while shifting", gray_o, p1);

    // correction load through a 96-bit path
    set_mode(1'b1);
    c0 = rnd192(); c1 = rnd192();
    shift_pkt(c0, 96, seen);
    shift_pkt(c1, 96, seen);
    check(seen[95:0] == c0[95:0], "R2 correction tap bit 95 chains after 96", seen, c0);
    check(corr_o == '0, "R4 hold before strobe", corr_o, '0);
    strobe_hi();
    check(corr_o == c1[95:0], "R4 transparent correction load", corr_o, c1[95:0]);
    strobe_lo();
    check(corr_o[5:0] == c1[5:0] && corr_o[95:90] == c1[95:90], "R4 channel fields",
          corr_o, c1[95:0]);
    check(gray_o == p1, "R4 gray untouched by correction load", gray_o, p1);

    // first grayscale load after correction needs an extra shift edge
    set_mode(1'b0);
    fl = 16'h1234; tf = 1'b0;
    open_flags_i = fl; therm_flag_i = tf;
    shift_pkt(p2, 192, seen);
    strobe_hi();
    check(gray_o == p1, "R7 no transparent load on first gray strobe", gray_o, p1);
    strobe_lo();
    check(gray_o == p1, "R7 still old after strobe", gray_o, p1);
    pulse(1'b0);
    check(gray_o == p2, "R7 extra shift edge completes load", gray_o, p2);
    s_exp = stat_word(fl, tf, c1[95:0]);
    p3 = rnd192();
    shift_pkt(p3, 192, seen);
    check(seen == s_exp, "R5 R7 status with correction copy", seen, s_exp);

    // later grayscale load behaves normally
    strobe_hi();
    check(gray_o == p3, "R7 later gray strobe is transparent", gray_o, p3);
    strobe_lo();

    // single shift on a long high level
    s_exp = stat_word(fl, tf, c1[95:0]);
    sdata_i = 1'b1; sclk_i = 1'b1;
    repeat (5) @(negedge clk);
    sclk_i = 1'b0;
    @(negedge clk);
    check(sdata_o == s_exp[190], "R1 one shift per rising edge", sdata_o, s_exp[190]);

    // mode change while strobe high
    p4 = rnd192();
    p4[191] = 1'b1; p4[95] = 1'b0;
    shift_pkt(p4, 192, seen);
    check(mode_err_o == 1'b0, "R8 no error before misuse", mode_err_o, 1'b0);
    fl = 16'h00F0; tf = 1'b1;
    open_flags_i = fl; therm_flag_i = tf;
    strobe_i = 1'b1;
    @(negedge clk);
    mode_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(mode_err_o == 1'b1, "R8 error raised", mode_err_o, 1'b1);
    check(corr_o == c1[95:0], "R8 correction register not targeted", corr_o, c1[95:0]);
    check(sdata_o == 1'b1, "R8 output tap stays on bit 191", sdata_o, 1'b1);
    mode_i = 1'b0;
    @(negedge clk);
    strobe_lo();
    check(gray_o == p4, "R8 gray load kept", gray_o, p4);
    s_exp = stat_word(fl, tf, c1[95:0]);

    // random grayscale rounds
    for (int it = 0; it < 4; it++) begin
      pk = rnd192();
      shift_pkt(pk, 192, seen);
      check(seen == s_exp, "R5 R6 random status readout", seen, s_exp);
      fl = 16'($urandom); tf = 1'($urandom);
      open_flags_i = fl; therm_flag_i = tf;
      strobe_hi();
      check(gray_o == pk, "R3 random gray load", gray_o, pk);
      strobe_lo();
      open_flags_i = ~fl;
      s_exp = stat_word(fl, tf, c1[95:0]);
    end
    check(mode_err_o == 1'b1, "R8 error stays set", mode_err_o, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule